// File: doc/BRIEF.md
# Sequential Instruction Prefetch Buffer

This block sits between a processor's instruction-fetch port and a flash array that returns one aligned 64-bit line per read. The processor presents a 16-bit word address. It asks for either a narrow (16-bit) or a wide (32-bit) instruction, and holds the request until it is acknowledged. The block keeps two line entries: the current line and the line right after it. It answers fetches from these entries, so one flash read can feed up to four narrow or two wide instructions.

With `pf_enable` high, the block refills on its own. Whenever the entry pair is not full and no read is in flight, it requests the missing line. A fetch into the next line advances the window by one line, which frees the second entry for the following prefetch. A fetch outside the two-line window flushes both entries and restarts at the target line. With `pf_enable` low (the reset value), only the lines a pending fetch needs are read, and the entries are dropped once that fetch is acknowledged.

The flash side is a small state machine with two states. In `RD_IDLE` no read is in flight; an issue decision raises `flash_req` for one cycle and takes the transition IDLE→WAIT. In `RD_WAIT` a read is in flight; `flash_ack` takes WAIT→IDLE. The buffer has four actions, each taken in its own cycle:
- **fill**: a returning line is stored if it is still wanted, otherwise it is discarded.
- **flush**: a fetch outside the window clears both entries.
- **advance**: a fetch into the next line shifts that line into the first entry.
- **drop**: in disabled mode the entries are cleared.

Top module: `seq_prefetch_buf`

## Requirements
- R1: A flash read is one `flash_req` cycle carrying `flash_line` = fetch word address >> 2, the line index. Exactly one `flash_ack` returns it later, and `flash_rdata` holds word k of that line in bits [16k+15:16k].
- R2: A narrow fetch (`fetch_wide`=0) is acknowledged with `fetch_data[15:0]` equal to the word at `fetch_addr`.
- R3: A wide fetch is acknowledged with `fetch_data` = {word(addr+1), word(addr)}, where addr+1 wraps to 0 at the top of the address space. A wide fetch at word 3 of a line is acknowledged only once both lines are buffered.
- R4: After reset, prefetching is off and both entries are empty. With no fetch pending, neither `flash_req` nor `fetch_ack` is raised.
- R5: With prefetching enabled, the block fills the current and the next line without any fetch. After enable, exactly two reads occur. A sequential walk over L lines that starts at a new target costs exactly L+1 reads. A fetch into a buffered line needs no read.
- R6: At most one read is in flight, and no request is raised while both entries hold data.
- R7: A fetch whose line is neither the current nor the next line flushes both entries and restarts reading at the target line. The data it returns is that of the target.
- R8: With prefetching disabled, a narrow fetch or a wide fetch that does not cross a line costs exactly one read, and a line-crossing wide fetch costs two. Nothing is kept, so repeating the same address reads again. No request is made without a pending fetch.
- R9: `fetch_ack` is high only while `fetch_req` is high. The requester holds address and width steady until the acknowledging cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pf_enable | input | 1 | Background prefetch enable |
| fetch_req | input | 1 | Fetch request, held until acknowledged |
| fetch_addr | input | ADDR_W | 16-bit word address of the fetch |
| fetch_wide | input | 1 | 1 = 32-bit instruction, 0 = 16-bit |
| fetch_ack | output | 1 | Fetch served this cycle |
| fetch_data | output | 2*WORD_W | {word(addr+1), word(addr)} |
| flash_req | output | 1 | One-cycle line read request |
| flash_line | output | ADDR_W-2 | Line index to read |
| flash_ack | input | 1 | Read data valid |
| flash_rdata | input | 4*WORD_W | Returned 64-bit line |

## Verification
The bench sweeps every address of the first lines with both widths in disabled mode and counts reads. A design that kept lines between fetches would show zero reads on a repeat, and a design that mishandled line-crossing wide fetches would show one read instead of two or return a wrong upper half. With prefetching enabled, it counts reads across a sequential walk after a jump. A design that never advanced the window, or re-read a line it had already prefetched, would miss the exact L+1 count, and one that kept prefetching past two lines would show extra reads while idle. Scattered jumps and the wide fetch at the last address check that a flush discards stale lines and in-flight data, and that the wrap to word 0 is handled.

// File: rtl/spb_pkg.sv
package spb_pkg;
    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_WAIT = 1'b1
    } rd_state_e;
endpackage

// File: rtl/spb_word_sel.sv
module spb_word_sel #(
    parameter int WORD_W = 16,
    parameter int WPL    = 4,
    localparam int OFS_W  = $clog2(WPL),
    localparam int LINE_W = WPL * WORD_W
) (
    input  logic [LINE_W-1:0]   line_a,
    input  logic [LINE_W-1:0]   line_b,
    input  logic [OFS_W-1:0]    ofs,
    output logic [2*WORD_W-1:0] pair
);
    logic [WORD_W-1:0] wa [WPL];

    for (genvar g = 0; g < WPL; g++) begin : g_split
        assign wa[g] = line_a[g*WORD_W +: WORD_W];
    end

    always_comb begin
        pair[WORD_W-1:0] = wa[ofs];
        if (ofs == OFS_W'(WPL-1))
            pair[2*WORD_W-1:WORD_W] = line_b[WORD_W-1:0];
        else
            pair[2*WORD_W-1:WORD_W] = wa[ofs + 1'b1];
    end
endmodule

// File: rtl/spb_read_fsm.sv
module spb_read_fsm
    import spb_pkg::*;
#(
    parameter int TAG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [TAG_W-1:0] issue_tag,
    input  logic             flash_ack,
    output logic             flash_req,
    output logic [TAG_W-1:0] flash_line,
    output logic             busy,
    output logic [TAG_W-1:0] rd_tag
);
    rd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (issue)     state_d = RD_WAIT;
            RD_WAIT: if (flash_ack) state_d = RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            rd_tag  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == RD_IDLE && issue)
                rd_tag <= issue_tag;
        end
    end

    always_comb begin
        flash_req  = 1'b0;
        busy       = 1'b0;
        flash_line = issue_tag;
        unique case (state_q)
            RD_IDLE: flash_req = issue;
            RD_WAIT: busy      = 1'b1;
            default: busy      = 1'b0;
        endcase
    end
endmodule

// File: rtl/seq_prefetch_buf.sv
module seq_prefetch_buf #(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 16,
    parameter int WPL    = 4,
    localparam int OFS_W  = $clog2(WPL),
    localparam int TAG_W  = ADDR_W - OFS_W,
    localparam int LINE_W = WPL * WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pf_enable,
    input  logic                fetch_req,
    input  logic [ADDR_W-1:0]   fetch_addr,
    input  logic                fetch_wide,
    output logic                fetch_ack,
    output logic [2*WORD_W-1:0] fetch_data,
    output logic                flash_req,
    output logic [TAG_W-1:0]    flash_line,
    input  logic                flash_ack,
    input  logic [LINE_W-1:0]   flash_rdata
);
    logic [TAG_W-1:0]  tag_q, tag_nx, line_idx, rd_tag, want_tag;
    logic [OFS_W-1:0]  ofs;
    logic [LINE_W-1:0] ent0_q, ent1_q;
    logic              v0_q, v1_q;
    logic              in_cur, in_next, far, adv, span, hit, issue, busy;

    assign line_idx = fetch_addr[ADDR_W-1:OFS_W];
    assign ofs      = fetch_addr[OFS_W-1:0];
    assign tag_nx   = tag_q + {{(TAG_W-1){1'b0}}, 1'b1};
    assign in_cur   = (line_idx == tag_q);
    assign in_next  = (line_idx == tag_nx);
    assign far      = fetch_req && !in_cur && !in_next;
    assign adv      = fetch_req && in_next;
    assign span     = fetch_wide && (ofs == OFS_W'(WPL-1));
    assign hit      = v0_q && in_cur && (!span || v1_q);
    assign want_tag = v0_q ? tag_nx : tag_q;

    // Issue decision: background refill when enabled, demand-only otherwise.
    always_comb begin
        if (pf_enable)
            issue = !far && !adv && !flash_ack && !(v0_q && v1_q);
        else
            issue = fetch_req && in_cur && !flash_ack &&
                    (!v0_q || (span && !v1_q));
    end

    // Line entries: fill, flush, advance, drop.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q  <= '0;
            v0_q   <= 1'b0;
            v1_q   <= 1'b0;
            ent0_q <= '0;
            ent1_q <= '0;
        end else if (flash_ack) begin
            if (!pf_enable && fetch_ack) begin
                v0_q <= 1'b0;
                v1_q <= 1'b0;
            end else if (rd_tag == tag_q && !v0_q) begin
                ent0_q <= flash_rdata;
                v0_q   <= 1'b1;
            end else if (rd_tag == tag_nx && v0_q && !v1_q) begin
                ent1_q <= flash_rdata;
                v1_q   <= 1'b1;
            end
        end else if (far) begin
            tag_q <= line_idx;
            v0_q  <= 1'b0;
            v1_q  <= 1'b0;
        end else if (adv) begin
            tag_q  <= tag_nx;
            ent0_q <= ent1_q;
            v0_q   <= v1_q && pf_enable;
            v1_q   <= 1'b0;
        end else if (!pf_enable && (fetch_ack || !fetch_req)) begin
            v0_q <= 1'b0;
            v1_q <= 1'b0;
        end
    end

    spb_read_fsm #(.TAG_W(TAG_W)) rd_fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (issue),
        .issue_tag  (want_tag),
        .flash_ack  (flash_ack),
        .flash_req  (flash_req),
        .flash_line (flash_line),
        .busy       (busy),
        .rd_tag     (rd_tag)
    );

    spb_word_sel #(.WORD_W(WORD_W), .WPL(WPL)) sel_i (
        .line_a (ent0_q),
        .line_b (ent1_q),
        .ofs    (ofs),
        .pair   (fetch_data)
    );

    assign fetch_ack = fetch_req && hit;

    logic unused_busy;
    assign unused_busy = busy;
endmodule

// File: rtl/spb_checker.sv
module spb_checker #(
    parameter int ADDR_W = 12,
    parameter int TAG_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pf_enable,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_wide,
    input logic              fetch_ack,
    input logic              flash_req,
    input logic [TAG_W-1:0]  flash_line,
    input logic              flash_ack,
    input logic              both_full
);
    logic outst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         outst <= 1'b0;
        else if (flash_req) outst <= 1'b1;
        else if (flash_ack) outst <= 1'b0;
    end

    // R6
    one_read_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outst |-> !flash_req);

    // R6
    full_buffer_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        both_full |-> !flash_req);

    // R9
    ack_only_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ack |-> fetch_req);

    // R8
    disabled_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pf_enable && !fetch_req) |-> !flash_req);

    // R1
    aligned_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pf_enable && flash_req && !fetch_wide) |->
            (flash_line == fetch_addr[ADDR_W-1:ADDR_W-TAG_W]));
endmodule

bind seq_prefetch_buf spb_checker #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pf_enable  (pf_enable),
    .fetch_req  (fetch_req),
    .fetch_addr (fetch_addr),
    .fetch_wide (fetch_wide),
    .fetch_ack  (fetch_ack),
    .flash_req  (flash_req),
    .flash_line (flash_line),
    .flash_ack  (flash_ack),
    .both_full  (v0_q && v1_q)
);

// File: tb/seq_prefetch_buf_tb.sv
module seq_prefetch_buf_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 12;
    localparam int TW  = AW - 2;
    localparam int LAT = 3;
    localparam int NW  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pf_enable = 1'b0;
    logic          fetch_req = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          fetch_wide = 1'b0;
    logic          fetch_ack;
    logic [31:0]   fetch_data;
    logic          flash_req;
    logic [TW-1:0] flash_line;
    logic          flash_ack = 1'b0;
    logic [63:0]   flash_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int reads  = 0;
    int cnt    = 0;
    logic [TW-1:0] last_line = '0;
    logic [TW-1:0] pend_line = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seq_prefetch_buf #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pf_enable(pf_enable),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_wide(fetch_wide),
        .fetch_ack(fetch_ack), .fetch_data(fetch_data),
        .flash_req(flash_req), .flash_line(flash_line),
        .flash_ack(flash_ack), .flash_rdata(flash_rdata)
    );

    function automatic logic [15:0] mem_word(input int a);
        logic [31:0] x;
        x = 32'(a % NW) * 32'd40503 + 32'd4660;
        return x[15:0];
    endfunction

    function automatic logic [63:0] line_data(input logic [TW-1:0] t);
        logic [63:0] d;
        for (int k = 0; k < 4; k++) d[16*k +: 16] = mem_word(int'(t) * 4 + k);
        return d;
    endfunction

    // Flash model: fixed latency, one read at a time.
    always @(posedge clk) begin
        flash_ack <= 1'b0;
        if (cnt == 1) begin
            flash_ack   <= 1'b1;
            flash_rdata <= line_data(pend_line);
        end
        if (cnt > 0) cnt <= cnt - 1;
        if (flash_req) begin
            cnt       <= LAT;
            pend_line <= flash_line;
            last_line <= flash_line;
            reads     <= reads + 1;
        end
    end

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_fetch(input int a, input bit wide, output logic [31:0] d);
        bit got;
        got = 1'b0;
        fetch_addr = AW'(a);
        fetch_wide = wide;
        fetch_req  = 1'b1;
        while (!got) begin
            #1;
            if (fetch_ack) begin
                d = fetch_data;
                got = 1'b1;
            end
            @(negedge clk);
        end
        fetch_req = 1'b0;
    endtask

    task automatic fetch_check(input int a, input bit wide, input string req);
        logic [31:0] d, e;
        do_fetch(a, wide, d);
        e = {mem_word((a + 1) % NW), mem_word(a % NW)};
        if (wide) check(d == e, req, 64'(d), 64'(e));
        else      check(d[15:0] == e[15:0], req, 64'(d[15:0]), 64'(e[15:0]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9: actual=hung expected=done (watchdog)");
        report();
    end

    initial begin
        int r0;
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        // R4 reset state
        check(fetch_ack == 1'b0, "R4", 64'(fetch_ack), 64'd0);
        check(flash_req == 1'b0, "R4", 64'(flash_req), 64'd0);
        check(reads == 0, "R4", 64'(reads), 64'd0);

        // Disabled mode sweep: R2 R3 R8 R1
        for (int a = 0; a < 16; a++) begin
            for (int w = 0; w < 2; w++) begin
                bit sp;
                sp = (w == 1) && (a % 4 == 3);
                r0 = reads;
                fetch_check(a, bit'(w), w ? "R3" : "R2");
                check(reads - r0 == (sp ? 2 : 1), "R8", 64'(reads - r0), sp ? 64'd2 : 64'd1);
                check(last_line == TW'((w ? a + 1 : a) >> 2), "R1",
                      64'(last_line), 64'((w ? a + 1 : a) >> 2));
            end
        end

        // Enable: exactly two background reads, then quiet (R5, R6)
        pf_enable = 1'b1;
        r0 = reads;
        repeat (20) @(negedge clk);
        check(reads - r0 == 2, "R5", 64'(reads - r0), 64'd2);
        repeat (20) @(negedge clk);
        check(reads - r0 == 2, "R6", 64'(reads - r0), 64'd2);

        // Jump then sequential narrow walk over 8 lines (R7, R5)
        r0 = reads;
        for (int i = 0; i < 32; i++) fetch_check(256 + i, 1'b0, "R7");
        repeat (12) @(negedge clk);
        check(reads - r0 == 9, "R5", 64'(reads - r0), 64'd9);

        // Buffered line needs no read (R5)
        r0 = reads;
        fetch_check(287, 1'b0, "R5");
        fetch_check(284, 1'b1, "R5");
        check(reads == r0, "R5", 64'(reads - r0), 64'd0);

        // Wide sequential walk, crossing lines (R3)
        for (int a = 512; a < 544; a++) fetch_check(a, 1'b1, "R3");

        // Scattered jumps, alternating width (R7)
        for (int i = 0; i < 40; i++) fetch_check((i * 997 + 13) % NW, bit'(i % 2), "R7");

        // Wide fetch at the last address wraps to word 0 (R3)
        fetch_check(NW - 1, 1'b1, "R3");

        // Back to disabled: repeat costs a read each time (R8)
        pf_enable = 1'b0;
        repeat (15) @(negedge clk);
        r0 = reads;
        fetch_check(100, 1'b0, "R8");
        fetch_check(100, 1'b0, "R8");
        check(reads - r0 == 2, "R8", 64'(reads - r0), 64'd2);
        repeat (10) @(negedge clk);
        check(reads - r0 == 2, "R8", 64'(reads - r0), 64'd2);
        check(fetch_ack == 1'b0, "R9", 64'(fetch_ack), 64'd0);
        d = fetch_data;
        report();
    end
endmodule